// File: doc/BRIEF.md
# Multi-Core Interrupt Steering Controller

This block collects a parameterised number of level-sensitive interrupt sources and steers them to up to four processor cores. A shared bank holds one global enable bit per source and a small routing word per source that names the cores allowed to receive it. Each core has its own bank holding a mask bit per source and an acknowledge register. Reading the acknowledge register gives the number of the lowest-numbered source that is currently deliverable to that core, or a spurious code when nothing is.

Software never performs read-modify-write on enables or masks. It writes a source number to a set or clear register, and only that one bit changes. One register port serves all banks. For a per-core register, the `bus_cpu` input picks the bank. Sources 0 and 1 normally carry the inter-core and message doorbell summaries. They are ordinary inputs here, and their low numbers give them first place in the acknowledge order. A parameter marks some sources as core-private (sources 3 and 5 by default). A private source bypasses the global enable and the routing word and is gated only by each core's mask.

Top module: `irq_steer_ctrl`

## Requirements
- R1: After reset every source is globally disabled, every per-core mask bit is set, every routing word is zero, `irq_out` is all zero and every acknowledge read returns 1023.
- R2: A write to offset 0x30 enables the source numbered in bits [9:0], and a write to offset 0x34 disables it. A number at or above NUM_SRC changes nothing.
- R3: A write to offset 0x48 masks, and a write to offset 0x4C unmasks, the source numbered in bits [9:0]. The change applies only to the core bank selected by `bus_cpu`.
- R4: The routing word of source n sits at offset 0x100 + 4·n. Bit c routes the source to core c. A read returns bits [NUM_CPUS-1:0] with all other bits zero.
- R5: A shared source is deliverable to a core only when four conditions hold: it is enabled, unmasked for that core, routed to that core, and its input is high. `irq_out[c]` is registered and follows the OR of the deliverable sources one clock after the state or input changes.
- R6: A private source (PRIV_SRC bit set) is deliverable to a core when its input is high and that core has it unmasked, whatever its enable bit and routing word hold.
- R7: A read of offset 0x44 returns, in bits [9:0], the lowest-numbered source deliverable to the selected core, or 1023 when there is none. The read has no side effect on any state.
- R8: A read of offset 0x00 returns NUM_SRC in bits [11:2], with all other bits zero.
- R9: Read data appears on `bus_rdata`, with `bus_rvalid` high, in the cycle after `bus_re` is sampled. `bus_rvalid` is low otherwise.
- R10: Sources are level-sensitive. When an input drops, that source leaves the acknowledge result and `irq_out` with no clearing access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_cpu | input | CPU_W | Core bank used by per-core registers |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| src_level | input | NUM_SRC | Level inputs of the interrupt sources |
| irq_out | output | NUM_CPUS | Registered interrupt request per core |

## Verification
Two things can land on the same clock edge: an acknowledge read and a change of a source input. Only the level sampled at that edge may decide the result. The bench raises a routed, enabled and unmasked source in the very cycle that it issues an acknowledge read, and the scoreboard expects the new source number. It then drops the source together with the next read, and the scoreboard expects the next source in order. The registered `irq_out` is checked one cycle later against the same levels.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int ID_W   = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'h3FF;

  localparam logic [ADDR_W-1:0] OFS_CTRL       = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_SET     = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR     = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_ACK        = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_MSK_SET    = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_MSK_CLR    = 12'h04C;
  localparam logic [ADDR_W-1:0] OFS_ROUTE_BASE = 12'h100;
endpackage

// File: rtl/irq_steer_first.sv
module irq_steer_first
  import irq_steer_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             hit,
  output logic [ID_W-1:0]  id
);
  // Scan from the top down so the lowest set bit is the last one written.
  always_comb begin
    hit = 1'b0;
    id  = SPURIOUS_ID;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_steer_global.sv
module irq_steer_global
  import irq_steer_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_CPUS = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         en_set,
  input  logic                         en_clr,
  input  logic [ID_W-1:0]              idx,
  input  logic                         route_we,
  input  logic [ID_W-1:0]              route_idx,
  input  logic [NUM_CPUS-1:0]          route_wdata,
  output logic [NUM_SRC-1:0]           enable_vec,
  output logic [NUM_SRC*NUM_CPUS-1:0]  route_flat,
  output logic [NUM_CPUS-1:0]          route_rd
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0]  enable_q;
  logic [NUM_CPUS-1:0] route_q [NUM_SRC];
  logic                idx_ok;
  logic                ridx_ok;

  assign idx_ok  = (idx < ID_W'(NUM_SRC));
  assign ridx_ok = (route_idx < ID_W'(NUM_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
    end else if (idx_ok) begin
      if (en_set) enable_q[idx[SRC_W-1:0]] <= 1'b1;
      else if (en_clr) enable_q[idx[SRC_W-1:0]] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NUM_SRC; s++) route_q[s] <= '0;
    end else if (route_we && ridx_ok) begin
      route_q[route_idx[SRC_W-1:0]] <= route_wdata;
    end
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_flat
    assign route_flat[s*NUM_CPUS +: NUM_CPUS] = route_q[s];
  end

  assign enable_vec = enable_q;
  assign route_rd   = ridx_ok ? route_q[route_idx[SRC_W-1:0]] : '0;

  a_r2_set_takes: assert property (@(posedge clk) disable iff (rst)
    (en_set && idx_ok) |=> enable_vec[$past(idx[SRC_W-1:0])]);
  a_r2_clr_takes: assert property (@(posedge clk) disable iff (rst)
    (en_clr && !en_set && idx_ok) |=> !enable_vec[$past(idx[SRC_W-1:0])]);
  a_r2_range_ignored: assert property (@(posedge clk) disable iff (rst)
    ((en_set || en_clr) && !idx_ok) |=> $stable(enable_vec));
endmodule

// File: rtl/irq_steer_cpu.sv
module irq_steer_cpu
  import irq_steer_pkg::*;
#(
  parameter int               NUM_SRC  = 32,
  parameter logic [NUM_SRC-1:0] PRIV_SRC = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               msk_set,
  input  logic               msk_clr,
  input  logic [ID_W-1:0]    idx,
  input  logic [NUM_SRC-1:0] src_level,
  input  logic [NUM_SRC-1:0] enable_vec,
  input  logic [NUM_SRC-1:0] route_col,
  output logic               irq_o,
  output logic [ID_W-1:0]    ack_id
);
  localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] gate;
  logic [NUM_SRC-1:0] deliver;
  logic               irq_q;
  logic               any_hit;
  logic               idx_ok;

  assign idx_ok = (idx < ID_W'(NUM_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else if (idx_ok) begin
      if (msk_set) mask_q[idx[SRC_W-1:0]] <= 1'b1;
      else if (msk_clr) mask_q[idx[SRC_W-1:0]] <= 1'b0;
    end
  end

  // Private sources skip the shared enable and routing gate.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_gate
    if (PRIV_SRC[s]) begin : g_priv
      assign gate[s] = 1'b1;
    end else begin : g_shared
      assign gate[s] = enable_vec[s] & route_col[s];
    end
  end

  assign deliver = src_level & ~mask_q & gate;

  irq_steer_first #(.WIDTH(NUM_SRC)) u_first (
    .vec (deliver),
    .hit (any_hit),
    .id  (ack_id)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= any_hit;
  end

  assign irq_o = irq_q;

  a_r7_idle_spurious: assert property (@(posedge clk) disable iff (rst)
    (ack_id == SPURIOUS_ID) |=> !irq_o);
  a_r7_ack_in_range: assert property (@(posedge clk) disable iff (rst)
    (ack_id != SPURIOUS_ID) |-> (ack_id < ID_W'(NUM_SRC)));
  a_r3_masked_not_acked: assert property (@(posedge clk) disable iff (rst)
    (msk_set && idx_ok) |=> (ack_id != $past(idx)));
  a_r10_irq_needs_level: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|src_level));
endmodule

// File: rtl/irq_steer_ctrl.sv
module irq_steer_ctrl
  import irq_steer_pkg::*;
#(
  parameter int                 NUM_CPUS = 4,
  parameter int                 NUM_SRC  = 32,
  parameter logic [NUM_SRC-1:0] PRIV_SRC = NUM_SRC'(32'h0000_0028),
  localparam int                CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [CPU_W-1:0]    bus_cpu,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_rvalid,
  input  logic [NUM_SRC-1:0]  src_level,
  output logic [NUM_CPUS-1:0] irq_out
);
  localparam logic [ADDR_W-1:0] ROUTE_END = OFS_ROUTE_BASE + ADDR_W'(4 * NUM_SRC);

  logic                        wr_en_set, wr_en_clr, wr_msk_set, wr_msk_clr;
  logic                        route_hit, wr_route;
  logic [ID_W-1:0]             wr_idx, route_idx;
  logic [ADDR_W-1:0]           route_ofs;
  logic [NUM_SRC-1:0]          enable_vec;
  logic [NUM_SRC*NUM_CPUS-1:0] route_flat;
  logic [NUM_CPUS-1:0]         route_rd;
  logic [NUM_SRC-1:0]          route_col [NUM_CPUS];
  logic [ID_W-1:0]             ack_all   [NUM_CPUS];
  logic                        cpu_ok;
  logic [DATA_W-1:0]           rd_next, rdata_q;
  logic                        rvalid_q;

  assign wr_idx     = bus_wdata[ID_W-1:0];
  assign wr_en_set  = bus_we && (bus_addr == OFS_EN_SET);
  assign wr_en_clr  = bus_we && (bus_addr == OFS_EN_CLR);
  assign wr_msk_set = bus_we && (bus_addr == OFS_MSK_SET);
  assign wr_msk_clr = bus_we && (bus_addr == OFS_MSK_CLR);
  assign route_hit  = (bus_addr >= OFS_ROUTE_BASE) && (bus_addr < ROUTE_END) &&
                      (bus_addr[1:0] == 2'b00);
  assign wr_route   = bus_we && route_hit;
  assign route_ofs  = bus_addr - OFS_ROUTE_BASE;
  assign route_idx  = ID_W'(route_ofs >> 2);
  assign cpu_ok     = (32'(bus_cpu) < NUM_CPUS);

  irq_steer_global #(.NUM_SRC(NUM_SRC), .NUM_CPUS(NUM_CPUS)) u_global (
    .clk         (clk),
    .rst         (rst),
    .en_set      (wr_en_set),
    .en_clr      (wr_en_clr),
    .idx         (wr_idx),
    .route_we    (wr_route),
    .route_idx   (route_idx),
    .route_wdata (bus_wdata[NUM_CPUS-1:0]),
    .enable_vec  (enable_vec),
    .route_flat  (route_flat),
    .route_rd    (route_rd)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_col
      assign route_col[c][s] = route_flat[s*NUM_CPUS + c];
    end

    irq_steer_cpu #(.NUM_SRC(NUM_SRC), .PRIV_SRC(PRIV_SRC)) u_cpu (
      .clk        (clk),
      .rst        (rst),
      .msk_set    (wr_msk_set && (32'(bus_cpu) == c)),
      .msk_clr    (wr_msk_clr && (32'(bus_cpu) == c)),
      .idx        (wr_idx),
      .src_level  (src_level),
      .enable_vec (enable_vec),
      .route_col  (route_col[c]),
      .irq_o      (irq_out[c]),
      .ack_id     (ack_all[c])
    );
  end

  always_comb begin
    rd_next = '0;
    if (bus_addr == OFS_CTRL) begin
      rd_next[11:2] = 10'(NUM_SRC);
    end else if (bus_addr == OFS_ACK) begin
      rd_next[ID_W-1:0] = cpu_ok ? ack_all[bus_cpu] : SPURIOUS_ID;
    end else if (route_hit) begin
      rd_next[NUM_CPUS-1:0] = route_rd;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_re;
      if (bus_re) rdata_q <= rd_next;
    end
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  a_r9_read_valid: assert property (@(posedge clk) disable iff (rst)
    bus_re |=> bus_rvalid);
  a_r9_idle_invalid: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> !bus_rvalid);
  a_r8_ctrl_count: assert property (@(posedge clk) disable iff (rst)
    (bus_re && bus_addr == OFS_CTRL) |=> (bus_rdata[11:2] == 10'(NUM_SRC)));
endmodule

// File: tb/irq_steer_ctrl_test.sv
`timescale 1ns/1ps
module irq_steer_ctrl_test;
  localparam int NC = 4;
  localparam int NS = 32;
  localparam logic [11:0] A_CTRL = 12'h000, A_ESET = 12'h030, A_ECLR = 12'h034,
                          A_ACK = 12'h044, A_MSET = 12'h048, A_MCLR = 12'h04C,
                          A_RT = 12'h100;
  localparam logic [31:0] SPUR = 32'd1023;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [1:0] bus_cpu = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic [NS-1:0] src_level = '0;
  logic [NC-1:0] irq_out;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  irq_steer_ctrl #(.NUM_CPUS(NC), .NUM_SRC(NS)) uut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_cpu(bus_cpu),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .src_level(src_level), .irq_out(irq_out)
  );

  // Monitor: pops one expected item per returned read.
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data %0h exp none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s got %0h exp %0h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int cpu);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  // Driver: pushes the expectation, then issues the read.
  task automatic rd(input logic [11:0] a, input int cpu, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_re = 1'b1; bus_addr = a; bus_cpu = 2'(cpu);
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s irq_out got %0h exp %0h", t, irq_out, e);
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog got timeout exp finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R8 reset state
    chk_irq('0, "R1 reset irq");
    rd(A_CTRL, 0, 32'h80, "R8 source count");
    rd(A_ACK, 0, SPUR, "R1 reset ack");
    rd(A_RT + 12'd28, 0, 32'h0, "R1 reset route");

    // R5: source 7 routed to core 1 and enabled, but still masked
    src_level[7] = 1'b1;
    wr(A_RT + 12'd28, 32'h2, 0);
    wr(A_ESET, 32'd7, 0);
    @(negedge clk);
    chk_irq('0, "R5 masked source");
    rd(A_ACK, 1, SPUR, "R5 masked ack");
    wr(A_MCLR, 32'd7, 1);
    @(negedge clk);
    chk_irq(4'b0010, "R5 deliver core1");
    rd(A_ACK, 1, 32'd7, "R5 ack core1");
    rd(A_ACK, 0, SPUR, "R3 other bank untouched");
    rd(A_ACK, 1, 32'd7, "R7 ack has no side effect");
    wr(A_RT + 12'd28, 32'hFFF2, 0);
    rd(A_RT + 12'd28, 0, 32'h2, "R4 route readback");

    // R7 lowest first, R10 level drop
    src_level[4] = 1'b1;
    wr(A_RT + 12'd16, 32'h2, 0);
    wr(A_ESET, 32'd4, 0);
    wr(A_MCLR, 32'd4, 1);
    rd(A_ACK, 1, 32'd4, "R7 lowest wins");
    src_level[4] = 1'b0;
    rd(A_ACK, 1, 32'd7, "R10 level drop");

    // R2 clear enable and out-of-range index
    wr(A_ECLR, 32'd7, 0);
    @(negedge clk);
    chk_irq('0, "R2 clear enable irq");
    rd(A_ACK, 1, SPUR, "R2 clear enable ack");
    src_level[8] = 1'b1;
    wr(A_RT + 12'd32, 32'h2, 0);
    wr(A_MCLR, 32'd8, 1);
    wr(A_ESET, 32'd40, 0);
    rd(A_ACK, 1, SPUR, "R2 out of range ignored");
    wr(A_ESET, 32'd8, 0);
    rd(A_ACK, 1, 32'd8, "R2 set enable");

    // R6 private source 3: no enable, no route
    src_level[3] = 1'b1;
    wr(A_MCLR, 32'd3, 2);
    @(negedge clk);
    chk_irq(4'b0110, "R6 private irq");
    rd(A_ACK, 2, 32'd3, "R6 private ack");
    rd(A_ACK, 1, 32'd8, "R3 private still masked core1");
    rd(A_ACK, 0, SPUR, "R3 core0 idle");
    wr(A_MSET, 32'd3, 2);
    @(negedge clk);
    chk_irq(4'b0010, "R3 set mask irq");
    rd(A_ACK, 2, SPUR, "R3 set mask ack");

    // Same-cycle: input edge together with an acknowledge read
    wr(A_RT + 12'd8, 32'h2, 0);
    wr(A_ESET, 32'd2, 0);
    wr(A_MCLR, 32'd2, 1);
    src_level[2] = 1'b1;
    rd(A_ACK, 1, 32'd2, "R10 rise with read");
    src_level[2] = 1'b0;
    rd(A_ACK, 1, 32'd8, "R10 fall with read");
    chk_irq(4'b0010, "R5 irq after fall");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R9 missing reads got %0d exp 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule